// File: doc/BRIEF.md
# Chained Serial Result Readout Port

This block hands a converter result to a host over a single serial line driven by the host's own clock. When the converter signals that a conversion has finished, the result word is captured into a shift register. While the port is selected, each active edge of the external serial clock advances that register by one bit. The most significant bit leaves first. Bits arriving on the serial input are pushed in behind the local word. Several ports can therefore be wired output-to-input in a chain, and one host line collects every result in turn.

The external clock is brought into the system clock domain through a two-stage synchroniser and an edge detector. A select input chooses whether rising or falling external edges are active. A format input turns the captured word into two's complement by flipping its top bit. If a conversion finishes while a read has started but has not yet delivered all word bits, the word being read is dropped and replaced by the new one, the bit position restarts, and a one-system-clock error pulse is raised.

Top module: `daisy_serial_port`

## Requirements
- R1: After reset, rdErr is 0, sdOut is 0, and the captured word is all zeros.
- R2: sdOut shows the register's top bit only while csN and rdN are both low; otherwise sdOut is held at 0, even while bits keep shifting.
- R3: A one-cycle convDone pulse captures resultIn. From the next cycle, sdOut presents bit WORD_W-1 first. After n active edges (n < WORD_W) it presents bit WORD_W-1-n.
- R4: When fmtTwos is 1, the captured word has its top bit inverted. When fmtTwos is 0, it is captured unchanged.
- R5: With clkInv at 0, only rising sdClk edges shift. With clkInv at 1, only falling edges shift.
- R6: sdClk edges that occur while csN is high do not shift the register.
- R7: The level on sdIn at active edge k (counted from 0 after the capture) appears on sdOut after active edge k+CHAIN_LEN. CHAIN_LEN defaults to WORD_W, so chained bits follow the local word with no gap.
- R8: A convDone pulse while between 1 and WORD_W-1 bits of the current word have been shifted causes these effects: rdErr is high for exactly the following system-clock cycle, the new word is captured, and the bit position restarts at the top bit.
- R9: A convDone pulse before any bit was shifted, or after all WORD_W bits were shifted, leaves rdErr low.
- R10: When convDone and a detected active edge fall in the same cycle, the capture wins and that edge is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sdClk | input | 1 | External serial clock from the host |
| csN | input | 1 | Active-low select; gates the external clock |
| rdN | input | 1 | Active-low read; with csN enables sdOut |
| sdIn | input | 1 | Serial input from the next port in the chain |
| clkInv | input | 1 | 0: rising sdClk edges active, 1: falling |
| fmtTwos | input | 1 | 1: invert top bit (two's complement) |
| resultIn | input | WORD_W | Conversion result to capture |
| convDone | input | 1 | One-cycle conversion-finished strobe |
| sdOut | output | 1 | Serial data output |
| rdErr | output | 1 | One-cycle pulse when a partial read is lost |

## Verification
A capture strobe can land in the same system-clock cycle as a synchronised active edge. The bench provokes this by driving sdClk to its active level and raising convDone exactly two cycles later, when the edge detector fires. Two bits into a read, this must drop the edge and capture the new word. It must also raise rdErr for one cycle. The next active edge must then present the new word's second bit rather than a shifted-past one.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  // Strobes from control to datapath, one system-clock cycle each.
  typedef struct packed {
    logic load;     // capture a fresh result word
    logic shift;    // advance the register by one bit
    logic flagErr;  // partial read overwritten this cycle
  } strobeT;

endpackage

// File: rtl/dsp_clk_sync.sv
module dsp_clk_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdClk,
  input  logic clkInv,
  output logic activeEdge
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lastLevel;
  logic                   riseSeen;
  logic                   fallSeen;
  logic                   syncLevel;

  assign syncLevel = syncChain[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= sdClk;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], sdClk};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= syncLevel;
  end

  assign riseSeen   = syncLevel & ~lastLevel;
  assign fallSeen   = ~syncLevel & lastLevel;
  assign activeEdge = clkInv ? fallSeen : riseSeen;

endmodule

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
#(
  parameter int WORD_W = 18,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   activeEdge,
  input  logic   csN,
  input  logic   convDone,
  output strobeT strb,
  output logic   rdErr
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W);

  logic [CNT_W-1:0] bitCnt;
  logic             readOpen;

  // A read is open once at least one bit left and not all word bits have.
  assign readOpen = (bitCnt != '0) && (bitCnt < LAST_CNT);

  always_comb begin
    strb         = '0;
    strb.load    = convDone;
    strb.shift   = activeEdge && !csN && !convDone;
    strb.flagErr = convDone && readOpen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.load) begin
      bitCnt <= '0;
    end else if (strb.shift && (bitCnt < LAST_CNT)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdErr <= 1'b0;
    else       rdErr <= strb.flagErr;
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> (bitCnt == '0)); // R8
  AST_CS_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !convDone) |=> $stable(bitCnt)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_CNT); // R7
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |=> !rdErr); // R8

endmodule

// File: rtl/dsp_datapath.sv
module dsp_datapath
  import dsp_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int CHAIN_LEN = WORD_W,
  localparam int PAD_W    = CHAIN_LEN - WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              fmtTwos,
  input  logic              sdIn,
  output logic              topBit
);

  logic [WORD_W-1:0]    fmtWord;
  logic [CHAIN_LEN-1:0] loadVal;
  logic [CHAIN_LEN-1:0] shReg;

  assign fmtWord = {resultIn[WORD_W-1] ^ fmtTwos, resultIn[WORD_W-2:0]};

  generate
    if (PAD_W == 0) begin : g_nopad
      assign loadVal = fmtWord;
    end else begin : g_pad
      assign loadVal = {fmtWord, PAD_W'(0)};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.load) begin
      shReg <= loadVal;
    end else if (strb.shift) begin
      shReg <= {shReg[CHAIN_LEN-2:0], sdIn};
    end
  end

  assign topBit = shReg[CHAIN_LEN-1];

  AST_LOAD_TOP: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (topBit == ($past(resultIn[WORD_W-1]) ^ $past(fmtTwos)))); // R4
  AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (shReg[0] == $past(sdIn))); // R7

endmodule

// File: rtl/daisy_serial_port.sv
module daisy_serial_port
  import dsp_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int CHAIN_LEN   = WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdClk,
  input  logic              csN,
  input  logic              rdN,
  input  logic              sdIn,
  input  logic              clkInv,
  input  logic              fmtTwos,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              convDone,
  output logic              sdOut,
  output logic              rdErr
);

  strobeT strb;
  logic   activeEdge;
  logic   topBit;

  dsp_clk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .sdClk     (sdClk),
    .clkInv    (clkInv),
    .activeEdge(activeEdge)
  );

  dsp_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .activeEdge(activeEdge),
    .csN       (csN),
    .convDone  (convDone),
    .strb      (strb),
    .rdErr     (rdErr)
  );

  dsp_datapath #(.WORD_W(WORD_W), .CHAIN_LEN(CHAIN_LEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .resultIn(resultIn),
    .fmtTwos (fmtTwos),
    .sdIn    (sdIn),
    .topBit  (topBit)
  );

  assign sdOut = (!csN && !rdN) ? topBit : 1'b0;

  AST_LOAD_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> !strb.shift); // R10

endmodule

// File: tb/daisy_serial_port_bench.sv
module daisy_serial_port_bench;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sdClk = 1'b0;
  logic         csN = 1'b1;
  logic         rdN = 1'b1;
  logic         sdIn = 1'b0;
  logic         clkInv = 1'b0;
  logic         fmtTwos = 1'b0;
  logic [W-1:0] resultIn = '0;
  logic         convDone = 1'b0;
  logic         sdOut;
  logic         rdErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  daisy_serial_port #(.WORD_W(W), .CHAIN_LEN(W)) u_daisy_serial_port (
    .clk(clk), .rstN(rstN), .sdClk(sdClk), .csN(csN), .rdN(rdN),
    .sdIn(sdIn), .clkInv(clkInv), .fmtTwos(fmtTwos), .resultIn(resultIn),
    .convDone(convDone), .sdOut(sdOut), .rdErr(rdErr)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Full active edge: active level, then back to idle.
  task automatic edgePulse(input logic din);
    sdClk = ~clkInv;
    sdIn  = din;
    waitNeg(4);
    sdClk = clkInv;
    waitNeg(4);
  endtask

  task automatic capture(input logic [W-1:0] w);
    resultIn = w;
    convDone = 1'b1;
    waitNeg(1);
    convDone = 1'b0;
  endtask

  task automatic setMode(input logic fmt, input logic inv);
    csN = 1'b1; rdN = 1'b1;
    fmtTwos = fmt; clkInv = inv; sdClk = inv;
    waitNeg(6);
  endtask

  function automatic logic [W-1:0] fmtOf(input logic [W-1:0] w, input logic f);
    return w ^ (W'(f) << (W-1));
  endfunction

  // Reads the word plus four chained bits; checks every output bit.
  task automatic readAll(input logic [W-1:0] w, input logic [7:0] pat);
    logic [W-1:0] fw;
    fw = fmtOf(w, fmtTwos);
    for (int n = 0; n < W + 4; n++) begin
      if (n < W) chk(sdOut, fw[W-1-n], "R3/R4/R5");
      else       chk(sdOut, pat[n-W], "R7");
      edgePulse(pat[n % 8]);
    end
    chk(sdOut, pat[4], "R7");
  endtask

  initial begin
    waitNeg(3);
    chk(sdOut, 1'b0, "R1");
    chk(rdErr, 1'b0, "R1");
    rstN = 1'b1;
    waitNeg(2);
    csN = 1'b0; rdN = 1'b0;
    waitNeg(1);
    chk(sdOut, 1'b0, "R1");
    chk(rdErr, 1'b0, "R1");

    // Sweep every word over every format / edge-select combination.
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < (1 << W); w++) begin
        setMode(m[0], m[1]);
        capture(W'(w));
        csN = 1'b0; rdN = 1'b0;
        waitNeg(1);
        readAll(W'(w), 8'(w * 37 + m * 11));
        chk(rdErr, 1'b0, "R9");
      end
    end

    // R2: read high hides output while shifting continues.
    setMode(1'b0, 1'b0);
    capture(6'b101101);
    csN = 1'b0; rdN = 1'b1;
    waitNeg(1);
    chk(sdOut, 1'b0, "R2");
    edgePulse(1'b0);
    chk(sdOut, 1'b0, "R2");
    rdN = 1'b0;
    waitNeg(1);
    chk(sdOut, 1'b0, "R2");   // bit 4 of 101101 after one shift
    edgePulse(1'b0);
    chk(sdOut, 1'b1, "R2");

    // R6: edges with csN high are ignored.
    setMode(1'b0, 1'b0);
    capture(6'b100000);
    for (int i = 0; i < 3; i++) edgePulse(1'b1);
    csN = 1'b0; rdN = 1'b0;
    waitNeg(1);
    chk(sdOut, 1'b1, "R6");
    edgePulse(1'b0);
    chk(sdOut, 1'b0, "R6");

    // R5: with clkInv=1 a rising-only pulse does not shift.
    setMode(1'b0, 1'b1);
    capture(6'b100000);
    csN = 1'b0; rdN = 1'b0;
    sdClk = 1'b0;           // falling edge: active, shifts once
    waitNeg(4);
    chk(sdOut, 1'b0, "R5");
    capture(6'b100000);
    waitNeg(1);
    sdClk = 1'b1;           // rising: inactive
    waitNeg(4);
    chk(sdOut, 1'b1, "R5");

    // R8: capture during a partial read.
    setMode(1'b0, 1'b0);
    capture(6'b111111);
    csN = 1'b0; rdN = 1'b0;
    edgePulse(1'b0); edgePulse(1'b0); edgePulse(1'b0);
    capture(6'b010011);
    chk(rdErr, 1'b1, "R8");
    chk(sdOut, 1'b0, "R8");
    waitNeg(1);
    chk(rdErr, 1'b0, "R8");
    readAll(6'b010011, 8'hA5);

    // R9: capture with nothing shifted, then right after a full word.
    capture(6'b110000);
    chk(rdErr, 1'b0, "R9");
    capture(6'b001111);
    chk(rdErr, 1'b0, "R9");
    for (int i = 0; i < W; i++) edgePulse(1'b1);
    capture(6'b100001);
    chk(rdErr, 1'b0, "R9");
    chk(sdOut, 1'b1, "R9");

    // R10: capture coincides with a detected active edge, two bits in.
    capture(6'b111111);
    edgePulse(1'b0); edgePulse(1'b0);
    resultIn = 6'b101000;
    sdClk = 1'b1;           // edge fires two cycles later
    waitNeg(2);
    convDone = 1'b1;
    waitNeg(1);
    convDone = 1'b0;
    chk(rdErr, 1'b1, "R10");
    chk(sdOut, 1'b1, "R10");
    waitNeg(3);
    sdClk = 1'b0;
    waitNeg(4);
    chk(sdOut, 1'b1, "R10");
    edgePulse(1'b0);
    chk(sdOut, 1'b0, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule